// File: doc/BRIEF.md
# Dual-Target Prioritized Interrupt Controller

This block gathers a set of level-sensitive peripheral request lines and raises one of two processor requests: a normal request or a fast request. Each line has its own configuration word with five settings. An enable bit turns the line on. A polarity bit makes the line active high or active low. A target bit routes the line to the normal or the fast request. A priority field sets the line's rank. A command bit clears the line's pending state. Each setting is guarded by its own write-enable bit in the same bus write, so software can change one setting without reading the word first.

Each target has a priority threshold and a vector base. A target's request is high when at least one routed line is pending, enabled, and ranked strictly above that target's threshold. The highest rank wins, and on equal rank the lowest line number wins. A read-only vector register gives the base plus eight times the winning line number. Lines are numbered from 1. Slot 0 of the configuration space is reserved. A simple single-cycle register bus gives access: writes take effect on the clock edge, and reads are combinational from the address. At most 31 lines are supported.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, every line is disabled, active high, routed to the normal request and at priority 0. Both thresholds and both vector bases are 0. Both requests are low and every configuration word reads 0.
- R2: Each line's pending state is registered from its input on every clock edge. The input is inverted when the polarity bit (word bit 9) is 1. Pending reads back at word bit 12.
- R3: The enable bit (word bit 10) takes the written value only when its write-enable (bit 19) is 1. A write with bit 19 set and bit 10 clear disables the line.
- R4: The priority (bits 3:0), target (bit 8, 1 = fast) and polarity (bit 9) fields change only when their write-enables (bits 16, 17, 18) are set in the same write. Otherwise they keep their values.
- R5: A write with bit 20 set clears that line's pending state on that edge, even while the input stays active. It can be combined with a disable in the same write. The pending state is set again on the next edge if the input is still active.
- R6: A target's request is high exactly when some line routed to it is pending, enabled and has priority strictly greater than the target's threshold. Priority 0 never requests. A threshold of 0 masks nothing else.
- R7: Among qualifying lines of one target, the highest priority wins, and on equal priority the lowest line number wins.
- R8: The vector of each target reads as its base plus 8 times the winning line number, or as the base alone when no line qualifies.
- R9: Configuration slot 0 (address 32) and addresses beyond the last line are unused. Writes to them change nothing, and reads return 0.
- R10: Word address 0/1 hold the normal/fast vector base, 2/3 the normal/fast threshold, and 4/5 the normal/fast vector (read-only; writes ignored). Line i sits at address 32+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | N_SRC (bits N_SRC:1) | Peripheral request lines, bit i is line i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_norm | output | 1 | Normal processor request |
| irq_fast | output | 1 | Fast processor request |

## Verification
The hardest case to reach from the ports is a clear-pending command issued while the line's input is still active. The line then drops for exactly one cycle and comes back, and a mis-sequenced clear would either hide that gap or make it last. Directed steps hold a line active. They issue the clear with and without a disable, then sample the request and the pending readback right after the clearing edge and again one edge later. Random traffic adds field writes with partial write-enable masks, equal-priority ties and threshold changes. A bench model of the configuration, pending and arbitration checks every cycle.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int PRIO_W = 4;

  // configuration word layout
  localparam int F_PRIO = 0;
  localparam int F_TGT  = 8;
  localparam int F_POL  = 9;
  localparam int F_EN   = 10;
  localparam int F_PEND = 12;
  localparam int W_PRIO = 16;
  localparam int W_TGT  = 17;
  localparam int W_POL  = 18;
  localparam int W_EN   = 19;
  localparam int C_CLR  = 20;

  // word address map
  localparam logic [ADDR_W-1:0] A_BASE0 = 6'd0;
  localparam logic [ADDR_W-1:0] A_BASE1 = 6'd1;
  localparam logic [ADDR_W-1:0] A_THR0  = 6'd2;
  localparam logic [ADDR_W-1:0] A_THR1  = 6'd3;
  localparam logic [ADDR_W-1:0] A_VEC0  = 6'd4;
  localparam logic [ADDR_W-1:0] A_VEC1  = 6'd5;
  localparam int                A_SRC0  = 32;

  typedef struct packed {
    logic              en;
    logic              pol;
    logic              tgt;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/icu_src.sv
module icu_src
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              src_in,
  output src_cfg_t          cfg,
  output logic              pend
);
  src_cfg_t cfg_d;
  logic     pend_d;

  always_comb begin
    cfg_d = cfg;
    if (wdata[W_PRIO]) cfg_d.prio = wdata[F_PRIO +: PRIO_W];
    if (wdata[W_TGT])  cfg_d.tgt  = wdata[F_TGT];
    if (wdata[W_POL])  cfg_d.pol  = wdata[F_POL];
    if (wdata[W_EN])   cfg_d.en   = wdata[F_EN];
    pend_d = (sel_wr && wdata[C_CLR]) ? 1'b0 : (src_in ^ cfg.pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      pend <= 1'b0;
    end else begin
      if (sel_wr) cfg <= cfg_d;
      pend <= pend_d;
    end
  end
endmodule

// File: rtl/icu_pick.sv
module icu_pick
  import icu_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 4
) (
  input  logic [N_SRC:1]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]     thr,
  output logic                  valid,
  output logic [IDX_W-1:0]      idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    best  = thr;
    idx   = '0;
    valid = 1'b0;
    for (int i = 1; i <= N_SRC; i++) begin
      if (req[i] && (prio_flat[(i-1)*PRIO_W +: PRIO_W] > best)) begin
        best  = prio_flat[(i-1)*PRIO_W +: PRIO_W];
        idx   = IDX_W'(i);
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import icu_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC:1]    src_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_norm,
  output logic              irq_fast
);
  localparam int IDX_W = $clog2(N_SRC + 1);
  localparam int N_TGT = 2;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  src_cfg_t                  cfg [N_SRC:1];
  logic [N_SRC:1]            sel_wr, pend_vec, en_vec, tgt_vec;
  logic [N_SRC*PRIO_W-1:0]   prio_flat;
  logic [DATA_W-1:0]         base_q [N_TGT];
  logic [PRIO_W-1:0]         thr_q  [N_TGT];
  logic [DATA_W-1:0]         vec    [N_TGT];
  logic [N_TGT-1:0]          win_valid;
  logic [IDX_W-1:0]          win_idx [N_TGT];

  for (genvar i = 1; i <= N_SRC; i++) begin : g_src
    assign sel_wr[i] = wr_en && (addr == ADDR_W'(A_SRC0 + i));
    icu_src u_src (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .sel_wr (sel_wr[i]),
      .wdata  (wdata),
      .src_in (src_in[i]),
      .cfg    (cfg[i]),
      .pend   (pend_vec[i])
    );
    assign en_vec[i]  = cfg[i].en;
    assign tgt_vec[i] = cfg[i].tgt;
    assign prio_flat[(i-1)*PRIO_W +: PRIO_W] = cfg[i].prio;
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    logic              wr_base, wr_thr;
    logic [DATA_W-1:0] base_r;
    logic [PRIO_W-1:0] thr_r;
    logic [N_SRC:1]    req;
    logic [IDX_W-1:0]  idx;
    logic              vld;

    assign wr_base = wr_en && (addr == ADDR_W'(32'(A_BASE0) + t));
    assign wr_thr  = wr_en && (addr == ADDR_W'(32'(A_THR0) + t));

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        base_r <= '0;
        thr_r  <= '0;
      end else begin
        if (wr_base) base_r <= wdata;
        if (wr_thr)  thr_r  <= wdata[PRIO_W-1:0];
      end
    end

    assign req = pend_vec & en_vec & ((t == 1) ? tgt_vec : ~tgt_vec);

    icu_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .req       (req),
      .prio_flat (prio_flat),
      .thr       (thr_r),
      .valid     (vld),
      .idx       (idx)
    );

    assign base_q[t]    = base_r;
    assign thr_q[t]     = thr_r;
    assign win_valid[t] = vld;
    assign win_idx[t]   = idx;
    assign vec[t]       = base_r + (DATA_W'(idx) << 3);
  end

  assign irq_norm = win_valid[0];
  assign irq_fast = win_valid[1];

  always_comb begin
    rdata = '0;
    case (addr)
      A_BASE0: rdata = base_q[0];
      A_BASE1: rdata = base_q[1];
      A_THR0:  rdata = DATA_W'(thr_q[0]);
      A_THR1:  rdata = DATA_W'(thr_q[1]);
      A_VEC0:  rdata = vec[0];
      A_VEC1:  rdata = vec[1];
      default: begin
        for (int i = 1; i <= N_SRC; i++) begin
          if (addr == ADDR_W'(A_SRC0 + i)) begin
            rdata[F_PRIO +: PRIO_W] = cfg[i].prio;
            rdata[F_TGT]            = cfg[i].tgt;
            rdata[F_POL]            = cfg[i].pol;
            rdata[F_EN]             = cfg[i].en;
            rdata[F_PEND]           = pend_vec[i];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk
  import icu_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [DATA_W-1:0]       wdata,
  input logic [N_SRC:1]          en_vec,
  input logic [N_SRC:1]          pend_vec,
  input logic [N_SRC:1]          tgt_vec,
  input logic [N_SRC*PRIO_W-1:0] prio_flat,
  input logic [PRIO_W-1:0]       thr0,
  input logic [PRIO_W-1:0]       thr1,
  input logic                    valid0,
  input logic                    valid1,
  input logic [IDX_W-1:0]        idx0,
  input logic [IDX_W-1:0]        idx1
);
  function automatic logic [PRIO_W-1:0] prio_of(input logic [N_SRC*PRIO_W-1:0] pf,
                                                input logic [IDX_W-1:0] k);
    prio_of = '0;
    for (int i = 1; i <= N_SRC; i++)
      if (k == IDX_W'(i)) prio_of = pf[(i-1)*PRIO_W +: PRIO_W];
  endfunction

  logic             in_rng;
  logic [IDX_W-1:0] wsrc;
  assign in_rng = (32'(addr) > A_SRC0) && (32'(addr) <= A_SRC0 + N_SRC);
  assign wsrc   = IDX_W'(32'(addr) - A_SRC0);

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_rng && wdata[W_EN]) |=> (en_vec[$past(wsrc)] == $past(wdata[F_EN]))); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wdata[W_EN]) |=> $stable(en_vec)); // R3
  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wdata[W_PRIO]) |=> $stable(prio_flat)); // R4
  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wdata[W_TGT]) |=> $stable(tgt_vec)); // R4
  AST_CLR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_rng && wdata[C_CLR]) |=> !pend_vec[$past(wsrc)]); // R5
  AST_NORM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    valid0 |-> (en_vec[idx0] && pend_vec[idx0] && !tgt_vec[idx0] &&
                (prio_of(prio_flat, idx0) > thr0))); // R6
  AST_FAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    valid1 |-> (en_vec[idx1] && pend_vec[idx1] && tgt_vec[idx1] &&
                (prio_of(prio_flat, idx1) > thr1))); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid0 || valid1) |-> ((!valid0 || (idx0 != '0)) && (!valid1 || (idx1 != '0)))); // R9
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .en_vec    (en_vec),
  .pend_vec  (pend_vec),
  .tgt_vec   (tgt_vec),
  .prio_flat (prio_flat),
  .thr0      (thr_q[0]),
  .thr1      (thr_q[1]),
  .valid0    (win_valid[0]),
  .valid1    (win_valid[1]),
  .idx0      (win_idx[0]),
  .idx1      (win_idx[1])
);

// File: tb/sim_dual_irq_ctrl.sv
module sim_dual_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N:1]    src_in;
  logic          wr_en;
  logic [5:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq_norm, irq_fast;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model
  bit        m_en   [1:N];
  bit        m_pol  [1:N];
  bit        m_tgt  [1:N];
  bit [3:0]  m_prio [1:N];
  bit        m_pend [1:N];
  bit [31:0] m_base [2];
  bit [3:0]  m_thr  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_ctrl #(.N_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int win(input int t);
    int best_i = 0;
    bit [3:0] best_p = m_thr[t];
    for (int i = 1; i <= N; i++)
      if (m_pend[i] && m_en[i] && (m_tgt[i] == t[0]) && (m_prio[i] > best_p)) begin
        best_p = m_prio[i];
        best_i = i;
      end
    return best_i;
  endfunction

  function automatic logic [31:0] exp_cfg(input int a);
    logic [31:0] v = '0;
    if (a > 32 && a <= 32 + N) begin
      v[3:0] = m_prio[a-32];
      v[8]   = m_tgt[a-32];
      v[9]   = m_pol[a-32];
      v[10]  = m_en[a-32];
      v[12]  = m_pend[a-32];
    end
    return v;
  endfunction

  task automatic model_edge(input logic [N:1] s, input bit w, input logic [5:0] a, input logic [31:0] d);
    for (int i = 1; i <= N; i++)
      m_pend[i] = (w && (int'(a) == 32 + i) && d[20]) ? 1'b0 : (s[i] ^ m_pol[i]);
    if (w) begin
      if (int'(a) > 32 && int'(a) <= 32 + N) begin
        if (d[16]) m_prio[a-32] = d[3:0];
        if (d[17]) m_tgt[a-32]  = d[8];
        if (d[18]) m_pol[a-32]  = d[9];
        if (d[19]) m_en[a-32]   = d[10];
      end else begin
        case (a)
          6'd0: m_base[0] = d;
          6'd1: m_base[1] = d;
          6'd2: m_thr[0]  = d[3:0];
          6'd3: m_thr[1]  = d[3:0];
          default: ;
        endcase
      end
    end
  endtask

  // checks run after the edge; each read settles within 1 time unit
  task automatic check_all(input int cfg_addr);
    int w0 = win(0);
    int w1 = win(1);
    chk(irq_norm == (w0 != 0), "R6 normal request", 32'(irq_norm), 32'(w0 != 0));
    chk(irq_fast == (w1 != 0), "R6 fast request", 32'(irq_fast), 32'(w1 != 0));
    addr = 6'd4; #1;
    chk(rdata == m_base[0] + 32'(w0 * 8), "R7/R8 normal vector", rdata, m_base[0] + 32'(w0 * 8));
    addr = 6'd5; #1;
    chk(rdata == m_base[1] + 32'(w1 * 8), "R7/R8 fast vector", rdata, m_base[1] + 32'(w1 * 8));
    addr = 6'(cfg_addr); #1;
    chk(rdata == exp_cfg(cfg_addr), "R2/R4 config readback", rdata, exp_cfg(cfg_addr));
  endtask

  task automatic step(input logic [N:1] s, input bit w, input logic [5:0] a, input logic [31:0] d, input int rb);
    @(negedge clk);
    src_in = s; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    model_edge(s, w, a, d);
    #1;
    wr_en = 1'b0;
    check_all(rb);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N:1] s;
    void'($urandom(32'd20240611));
    for (int i = 1; i <= N; i++) begin
      m_en[i] = 0; m_pol[i] = 0; m_tgt[i] = 0; m_prio[i] = 0; m_pend[i] = 0;
    end
    m_base[0] = 0; m_base[1] = 0; m_thr[0] = 0; m_thr[1] = 0;
    rst_n = 1'b0; src_in = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(!irq_norm && !irq_fast, "R1 requests low", {30'b0, irq_norm, irq_fast}, 0);
    addr = 6'd35; #1;
    chk(rdata == 0, "R1 config word zero", rdata, 0);
    addr = 6'd4; #1;
    chk(rdata == 0, "R1 vector zero", rdata, 0);

    // line 2: prio 5, normal, enabled, input high
    step(8'b0000_0010, 1, 6'd34, 32'h000B_0405, 34);
    step(8'b0000_0010, 0, 6'd0, 0, 34);
    chk(irq_norm === 1'b1, "R6 line 2 requests", 32'(irq_norm), 1);
    addr = 6'd4; #1;
    chk(rdata == 32'd16, "R8 vector of line 2", rdata, 16);

    // R6 threshold equal masks, one below passes
    step(8'b0000_0010, 1, 6'd2, 32'd5, 34);
    chk(irq_norm === 1'b0, "R6 threshold equal masks", 32'(irq_norm), 0);
    step(8'b0000_0010, 1, 6'd2, 32'd4, 34);
    chk(irq_norm === 1'b1, "R6 threshold below passes", 32'(irq_norm), 1);
    step(8'b0000_0010, 1, 6'd2, 32'd0, 34);

    // R7 tie: line 5 same prio, lower index 2 wins
    step(8'b0001_0010, 1, 6'd37, 32'h000B_0405, 37);
    step(8'b0001_0010, 0, 6'd0, 0, 37);
    addr = 6'd4; #1;
    chk(rdata == 32'd16, "R7 tie to lowest index", rdata, 16);
    // R4 raise prio only
    step(8'b0001_0010, 1, 6'd37, 32'h0001_0007, 37);
    addr = 6'd4; #1;
    chk(rdata == 32'd40, "R7 higher priority wins", rdata, 40);
    addr = 6'd37; #1;
    chk(rdata == 32'h0000_1407, "R4 other fields kept", rdata, 32'h1407);
    // R3 enable write-enable alone disables
    step(8'b0001_0010, 1, 6'd37, 32'h0008_0000, 37);
    addr = 6'd37; #1;
    chk(rdata == 32'h0000_1007, "R3 disabled, prio kept", rdata, 32'h1007);

    // R5 clear with disable on line 2, input still high
    step(8'b0001_0010, 1, 6'd34, 32'h0018_0000, 34);
    chk(irq_norm === 1'b0, "R5 clear and disable", 32'(irq_norm), 0);
    step(8'b0001_0010, 0, 6'd0, 0, 34);
    addr = 6'd34; #1;
    chk(rdata[12] === 1'b1, "R2 pending returns", 32'(rdata[12]), 1);
    // R5 clear only: one-cycle gap
    step(8'b0001_0010, 1, 6'd34, 32'h0008_0400, 34);
    step(8'b0001_0010, 1, 6'd34, 32'h0010_0000, 34);
    chk(irq_norm === 1'b0, "R5 gap after clear", 32'(irq_norm), 0);
    step(8'b0001_0010, 0, 6'd0, 0, 34);
    chk(irq_norm === 1'b1, "R5 request resumes", 32'(irq_norm), 1);

    // R2 polarity low on line 7, fast target, base 0x100
    step(8'b0001_0010, 1, 6'd1, 32'h100, 39);
    step(8'b0001_0010, 1, 6'd39, 32'h000F_0703, 39);
    step(8'b0001_0010, 0, 6'd0, 0, 39);
    chk(irq_fast === 1'b1, "R2 active-low line requests", 32'(irq_fast), 1);
    addr = 6'd5; #1;
    chk(rdata == 32'h138, "R8 fast vector line 7", rdata, 32'h138);

    // R9 slot 0 and beyond ignored; R10 vector write ignored
    step(8'b0001_0010, 1, 6'd32, 32'hFFFF_FFFF, 32);
    addr = 6'd32; #1;
    chk(rdata == 0, "R9 slot 0 reads zero", rdata, 0);
    step(8'b0001_0010, 1, 6'd41, 32'hFFFF_FFFF, 41);
    step(8'b0001_0010, 1, 6'd4, 32'hFFFF_FFFF, 34);
    addr = 6'd4; #1;
    chk(rdata == 32'd16, "R10 vector read-only", rdata, 16);

    // R6 priority 0 never requests
    step(8'b0000_0001, 1, 6'd33, 32'h000B_0400, 33);
    step(8'b0000_0001, 0, 6'd0, 0, 33);
    chk(irq_norm === 1'b0, "R6 priority 0 silent", 32'(irq_norm), 0);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom % 10;
      bit w = 1;
      logic [5:0] a;
      logic [31:0] d = $urandom;
      s = N'($urandom);
      if (r < 6)       a = 6'(32 + ($urandom % (N + 2)));
      else if (r == 6) begin a = 6'(2 + ($urandom % 2)); d = $urandom % 6; end
      else if (r == 7) a = 6'($urandom % 6);
      else begin w = 0; a = 6'd0; end
      step(s, w, a, d, 33 + ($urandom % N));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule